// File: doc/BRIEF.md
# Serial Programming Row-Erase Controller

This block is the target-side logic of a two-wire serial programming port. It takes a programming clock and a data line from an external programmer and rebuilds the frames they carry. It keeps a 24-bit byte address pointer and a write-start bit, and from them it starts the erase of one 64-byte row in the program array. The array is outside the block. The block reaches it through a one-cycle request that carries the row address, and the array answers with a done pulse once its self-timed erase has finished.

Every frame has 20 bits: a 4-bit command followed by a 16-bit payload. Only core-instruction frames act on the block. A programmer loads the pointer one byte at a time and then sets the write-start bit. It then sends two further frames, normally NOPs. The erase is launched on the fourth programming clock of the second of those frames. Per-block protection inputs, and a limit on the size of the memory, can each refuse the erase. A refused erase is reported through an error flag.

The programming clock and data are oversampled in the system clock domain. The programming clock must therefore stay high for at least four system clocks and low for at least four.

Top module: `serprog_row_erase`

## Requirements
- R1: While reset is high, and after it, the pointer reads 0, the write-start bit and the error flag are 0, and no erase request is issued. The first programming-clock falling edge after reset is taken as bit 0 of a command field.
- R2: Data is sampled on each falling edge of the programming clock, least significant bit first. Bits 0 to 3 form the command and bits 4 to 19 form the payload. Only command 4'b0000 (a core instruction) has any effect; frames with any other command leave the pointer and the write-start bit unchanged.
- R3: In a core instruction, payload bits 15:12 select the operation. 4'h1 loads pointer bits 23:16 from payload bits 7:0, 4'h2 loads bits 15:8, 4'h3 loads bits 7:0, 4'h8 sets the write-start bit, and 4'h0 is a NOP. Every other value has no effect.
- R4: An erase is launched only on the 4th programming-clock falling edge of the second frame that follows the frame which set the write-start bit. The request appears before the 5th falling edge of that frame.
- R5: The erase request is high for exactly one system-clock cycle. It carries the row address, which is the pointer with its low 6 bits cleared.
- R6: The write-start bit stays 1 from the frame that sets it until the erase-done pulse that follows the request, and is 0 after that pulse. An erase-done pulse at any other time has no effect.
- R7: While the write-start bit is 1, frames are still received. Pointer loads take effect, but another set-write-start frame is ignored and causes no extra erase after the current one ends.
- R8: The launch is refused under either of two conditions. The first is that a pointer bit above bit 14 is set, meaning the address is beyond the 32 KiB memory. The second is that the protection input selected by pointer bits 14:13 is 1. A refused launch issues no request, clears the write-start bit and sets the error flag. The flag clears when the write-start bit is next set.
- R9: The row address output holds its value from the request until the erase-done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_clk_i | input | 1 | Programming clock from the external programmer |
| pgm_dat_i | input | 1 | Programming data line (input only) |
| blk_prot_i | input | 4 | Per-block protection; a 1 forbids erasing rows in that 8 KiB block |
| erase_done_i | input | 1 | One-cycle pulse from the array when its erase has finished |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_row_o | output | 24 | 64-byte-aligned row address of the current erase |
| wr_start_o | output | 1 | Write-start bit |
| err_o | output | 1 | Set when an erase was refused by protection or range |
| ptr_o | output | 24 | Byte address pointer |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold cycle by cycle:
- the request is a single-cycle pulse;
- the row address is aligned and stays stable while an erase is busy;
- a request follows only the fourth-bit event of an armed controller, and never a protected or out-of-range address;
- the write-start bit holds until the done pulse;
- the frame bit counter stays in range.

Other behaviour can only be seen in the bench scenarios, because it spans whole frames. This covers the exact frame and bit position of the launch, how commands and payload opcodes are decoded, and the fact that a second set-write-start frame sent during an erase is ignored. It also covers the sticky error flag and how it is cleared, and randomized mixes of pointers, protection masks and foreign commands checked against a reference model.

// File: rtl/spe_pkg.sv
package spe_pkg;

    localparam int FRAME_BITS = 20;
    localparam int CMD_BITS   = 4;
    localparam int PAY_BITS   = 16;
    localparam int ADDR_W     = 24;
    localparam int ROW_AW     = 6;

    localparam logic [CMD_BITS-1:0] CMD_CORE = 4'b0000;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LD_U  = 4'h1,
        OP_LD_H  = 4'h2,
        OP_LD_L  = 4'h3,
        OP_START = 4'h8
    } pay_op_e;

    typedef struct packed {
        logic [CMD_BITS-1:0] cmd;
        logic [PAY_BITS-1:0] payload;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM0,
        ST_ARM1,
        ST_BUSY
    } ctl_st_e;

    function automatic logic [3:0] pay_op(input logic [PAY_BITS-1:0] p);
        return p[15:12];
    endfunction

    function automatic logic [ADDR_W-1:0] row_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ROW_AW], {ROW_AW{1'b0}}};
    endfunction

endpackage

// File: rtl/spe_frame_rx.sv
module spe_frame_rx
    import spe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pgm_clk_i,
    input  logic   pgm_dat_i,
    output logic   frame_v_o,
    output frame_t frame_o,
    output logic   cmd4_v_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);

    logic [2:0]             ck_sync;
    logic [1:0]             dt_sync;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_BITS-2:0]  sr;
    logic                   fall;
    logic [FRAME_BITS-1:0]  word;

    assign fall = ck_sync[2] & ~ck_sync[1];
    assign word = {dt_sync[1], sr};

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sync <= '0;
            dt_sync <= '0;
        end else begin
            ck_sync <= {ck_sync[1:0], pgm_clk_i};
            dt_sync <= {dt_sync[0], pgm_dat_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            sr        <= '0;
            frame_v_o <= 1'b0;
            cmd4_v_o  <= 1'b0;
            frame_o   <= '0;
        end else begin
            frame_v_o <= 1'b0;
            cmd4_v_o  <= 1'b0;
            if (fall) begin
                sr       <= word[FRAME_BITS-1:1];
                cmd4_v_o <= (bit_cnt == CMD_LAST);
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt         <= '0;
                    frame_v_o       <= 1'b1;
                    frame_o.cmd     <= word[CMD_BITS-1:0];
                    frame_o.payload <= word[FRAME_BITS-1:CMD_BITS];
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2: bit counter never leaves the frame
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LAST_BIT);

    // R4: fourth-bit event and frame-end event are distinct clock positions
    p_events_apart_r4: assert property (@(posedge clk) disable iff (rst)
        !(frame_v_o && cmd4_v_o));

endmodule

// File: rtl/spe_erase_ctl.sv
module spe_erase_ctl
    import spe_pkg::*;
#(
    parameter int MEM_AW = 15,
    parameter int BLK_AW = 13,
    localparam int NBLK  = 1 << (MEM_AW - BLK_AW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_v_i,
    input  frame_t            frame_i,
    input  logic              cmd4_v_i,
    input  logic [NBLK-1:0]   blk_prot_i,
    input  logic              erase_done_i,
    output logic              erase_req_o,
    output logic [ADDR_W-1:0] erase_row_o,
    output logic              wr_start_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] ptr_o
);
    ctl_st_e           st;
    logic [ADDR_W-1:0] ptr_q;
    logic              is_core;
    logic [3:0]        op;
    logic              prot_hit;
    logic              unused_bits;

    assign is_core     = frame_v_i && (frame_i.cmd == CMD_CORE);
    assign op          = pay_op(frame_i.payload);
    assign unused_bits = ^frame_i.payload[11:8];
    assign prot_hit    = (|ptr_q[ADDR_W-1:MEM_AW]) ||
                         blk_prot_i[ptr_q[MEM_AW-1:BLK_AW]];
    assign ptr_o       = ptr_q;
    assign wr_start_o  = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (is_core) begin
            case (op)
                OP_LD_U: ptr_q[23:16] <= frame_i.payload[7:0];
                OP_LD_H: ptr_q[15:8]  <= frame_i.payload[7:0];
                OP_LD_L: ptr_q[7:0]   <= frame_i.payload[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            erase_req_o <= 1'b0;
            erase_row_o <= '0;
            err_o       <= 1'b0;
        end else begin
            erase_req_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (is_core && op == OP_START) begin
                        st    <= ST_ARM0;
                        err_o <= 1'b0;
                    end
                end
                ST_ARM0: begin
                    if (frame_v_i) st <= ST_ARM1;
                end
                ST_ARM1: begin
                    if (cmd4_v_i) begin
                        if (prot_hit) begin
                            st    <= ST_IDLE;
                            err_o <= 1'b1;
                        end else begin
                            st          <= ST_BUSY;
                            erase_req_o <= 1'b1;
                            erase_row_o <= row_base(ptr_q);
                        end
                    end
                end
                ST_BUSY: begin
                    if (erase_done_i) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: request lasts one cycle
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        erase_req_o |=> !erase_req_o);

    // R5: row address aligned to 64 bytes
    p_row_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        erase_req_o |-> (erase_row_o[ROW_AW-1:0] == '0));

    // R4: request only right after the fourth-bit event of an armed controller
    p_launch_pos_r4: assert property (@(posedge clk) disable iff (rst)
        erase_req_o |-> ($past(cmd4_v_i) && $past(st) == ST_ARM1));

    // R8: no request for a protected or out-of-range row
    p_no_prot_req_r8: assert property (@(posedge clk) disable iff (rst)
        erase_req_o |-> !$past(prot_hit));

    // R6: write-start bit holds while the array has not reported done
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !erase_done_i) |=> wr_start_o);

    // R9: row address stable during a busy erase
    p_row_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !erase_req_o) |-> $stable(erase_row_o));

endmodule

// File: rtl/serprog_row_erase.sv
module serprog_row_erase
    import spe_pkg::*;
#(
    parameter int MEM_AW = 15,
    parameter int BLK_AW = 13,
    localparam int NBLK  = 1 << (MEM_AW - BLK_AW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_clk_i,
    input  logic              pgm_dat_i,
    input  logic [NBLK-1:0]   blk_prot_i,
    input  logic              erase_done_i,
    output logic              erase_req_o,
    output logic [ADDR_W-1:0] erase_row_o,
    output logic              wr_start_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] ptr_o
);
    logic   frame_v;
    frame_t frame;
    logic   cmd4_v;

    spe_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .pgm_clk_i (pgm_clk_i),
        .pgm_dat_i (pgm_dat_i),
        .frame_v_o (frame_v),
        .frame_o   (frame),
        .cmd4_v_o  (cmd4_v)
    );

    spe_erase_ctl #(
        .MEM_AW (MEM_AW),
        .BLK_AW (BLK_AW)
    ) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .frame_v_i    (frame_v),
        .frame_i      (frame),
        .cmd4_v_i     (cmd4_v),
        .blk_prot_i   (blk_prot_i),
        .erase_done_i (erase_done_i),
        .erase_req_o  (erase_req_o),
        .erase_row_o  (erase_row_o),
        .wr_start_o   (wr_start_o),
        .err_o        (err_o),
        .ptr_o        (ptr_o)
    );

endmodule

// File: tb/serprog_row_erase_tb_top.sv
module serprog_row_erase_tb_top;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pgm_clk = 1'b0;
    logic        pgm_dat = 1'b0;
    logic [3:0]  prot = 4'b0000;
    logic        resp_done = 1'b0;
    logic        stray_done = 1'b0;
    logic        done_w;
    logic        erase_req;
    logic [23:0] erase_row;
    logic        wr_start;
    logic        err;
    logic [23:0] ptr;

    int n_chk = 0;
    int n_fail = 0;
    int fr_idx = 0;
    int bit_idx = 0;
    int req_cnt = 0;
    int req_fr = 0;
    int req_bit = 0;
    logic [23:0] req_row = '0;
    int done_delay = 30;
    int cd = 0;
    bit finished = 0;
    logic [23:0] mptr = '0;

    assign done_w = resp_done | stray_done;

    always #10 clk = ~clk;

    serprog_row_erase dut_i (
        .clk          (clk),
        .rst          (rst),
        .pgm_clk_i    (pgm_clk),
        .pgm_dat_i    (pgm_dat),
        .blk_prot_i   (prot),
        .erase_done_i (done_w),
        .erase_req_o  (erase_req),
        .erase_row_o  (erase_row),
        .wr_start_o   (wr_start),
        .err_o        (err),
        .ptr_o        (ptr)
    );

    // request monitor and array model
    always @(negedge clk) begin
        resp_done = 1'b0;
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) resp_done = 1'b1;
        end
        if (!rst && erase_req) begin
            req_cnt = req_cnt + 1;
            req_fr  = fr_idx;
            req_bit = bit_idx;
            req_row = erase_row;
            cd      = done_delay;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] cmd, input logic [15:0] pay);
        logic [19:0] w;
        w = {pay, cmd};
        fr_idx++;
        bit_idx = 0;
        for (int i = 0; i < 20; i++) begin
            pgm_dat = w[i];
            pgm_clk = 1'b1;
            wait_clk(HALF);
            pgm_clk = 1'b0;
            bit_idx = i + 1;
            wait_clk(HALF);
        end
        wait_clk(HALF);
    endtask

    task automatic load_ptr(input logic [23:0] a);
        send(4'h0, {4'h1, 4'h0, a[23:16]});
        send(4'h0, {4'h2, 4'h0, a[15:8]});
        send(4'h0, {4'h3, 4'h0, a[7:0]});
        mptr = a;
    endtask

    function automatic bit model_prot(input logic [23:0] a, input logic [3:0] m);
        return (a[23:15] != 0) || m[a[14:13]];
    endfunction

    // full erase attempt; returns after the array has answered
    task automatic erase_seq(input string tag);
        int c0;
        int sf;
        bit pr;
        c0 = req_cnt;
        pr = model_prot(mptr, prot);
        send(4'h0, 16'h8000);
        sf = fr_idx;
        chk(wr_start == 1'b1, "R6", 32'(wr_start), 32'd1);
        send(4'h0, 16'h0000);
        chk(req_cnt == c0, "R4", req_cnt, c0);
        send(4'h0, 16'h0000);
        wait_clk(done_delay + 10);
        if (pr) begin
            chk(req_cnt == c0, "R8", req_cnt, c0);
            chk(err == 1'b1, "R8", 32'(err), 32'd1);
            chk(wr_start == 1'b0, "R8", 32'(wr_start), 32'd0);
        end else begin
            chk(req_cnt == c0 + 1, "R4", req_cnt, c0 + 1);
            chk(req_fr == sf + 2 && req_bit == 4, "R4", (req_fr - sf) * 256 + req_bit, 32'h204);
            chk(req_row == {mptr[23:6], 6'd0}, "R5", req_row, {mptr[23:6], 6'd0});
            chk(err == 1'b0, "R8", 32'(err), 32'd0);
            chk(wr_start == 1'b0, "R6", 32'(wr_start), 32'd0);
        end
        if (tag.len() == 0) ;
    endtask

    initial begin
        wait_clk(5);
        // R1: reset state
        chk(ptr == 24'd0, "R1", ptr, 0);
        chk(wr_start == 1'b0 && err == 1'b0 && erase_req == 1'b0, "R1",
            {wr_start, err, erase_req}, 0);
        rst = 1'b0;
        wait_clk(3);

        // R1, R3: first frame after reset decodes as a command field
        load_ptr(24'h0012A7);
        chk(ptr == 24'h0012A7, "R3", ptr, 24'h0012A7);

        // R2: non-core commands with a load payload have no effect
        send(4'h1, {4'h3, 4'h0, 8'h55});
        send(4'hF, 16'h8000);
        chk(ptr == mptr, "R2", ptr, mptr);
        chk(wr_start == 1'b0, "R2", 32'(wr_start), 0);

        // R3: unknown opcode is ignored
        send(4'h0, {4'h5, 4'h0, 8'hEE});
        chk(ptr == mptr, "R3", ptr, mptr);

        // R6: stray done while idle does nothing
        stray_done = 1'b1; wait_clk(1); stray_done = 1'b0; wait_clk(2);
        chk(wr_start == 1'b0 && req_cnt == 0, "R6", 32'(wr_start), 0);

        // R4, R5, R6: basic erase
        erase_seq("basic");

        // R6: done pulse while armed is ignored
        send(4'h0, 16'h8000);
        stray_done = 1'b1; wait_clk(1); stray_done = 1'b0; wait_clk(2);
        chk(wr_start == 1'b1, "R6", 32'(wr_start), 1);
        send(4'h0, 16'h0000);
        send(4'h0, 16'h0000);
        wait_clk(done_delay + 10);
        chk(req_cnt == 2 && wr_start == 1'b0, "R6", req_cnt, 2);

        // R7, R9: activity during a long erase
        done_delay = 1500;
        load_ptr(24'h003FC1);
        send(4'h0, 16'h8000);
        send(4'h0, 16'h0000);
        send(4'h0, 16'h0000);
        chk(req_cnt == 3, "R7", req_cnt, 3);
        send(4'h0, 16'h8000);
        chk(wr_start == 1'b1, "R7", 32'(wr_start), 1);
        send(4'h0, {4'h3, 4'h0, 8'h07});
        mptr[7:0] = 8'h07;
        chk(ptr == mptr, "R7", ptr, mptr);
        send(4'h0, 16'h0000);
        send(4'h0, 16'h0000);
        chk(req_cnt == 3, "R7", req_cnt, 3);
        chk(erase_row == 24'h003FC0, "R9", erase_row, 24'h003FC0);
        for (int k = 0; k < 2000 && wr_start; k++) wait_clk(1);
        chk(wr_start == 1'b0, "R6", 32'(wr_start), 0);
        send(4'h0, 16'h0000);
        send(4'h0, 16'h0000);
        chk(req_cnt == 3, "R7", req_cnt, 3);
        done_delay = 30;

        // R8: protected block, then out of range, then error clear
        prot = 4'b0100;
        load_ptr(24'h004567);
        erase_seq("prot");
        prot = 4'b0000;
        load_ptr(24'h010000);
        erase_seq("range");
        load_ptr(24'h000040);
        send(4'h0, 16'h8000);
        chk(err == 1'b0, "R8", 32'(err), 0);
        send(4'h0, 16'h0000);
        send(4'h0, 16'h0000);
        wait_clk(done_delay + 10);

        // random mix
        void'($urandom(32'h5EED));
        for (int it = 0; it < 12; it++) begin
            logic [23:0] a;
            a = {7'd0, 17'($urandom)};
            prot = 4'($urandom);
            load_ptr(a);
            send(4'($urandom_range(15, 1)), 16'($urandom));
            chk(ptr == mptr, "R2", ptr, mptr);
            erase_seq("rand");
        end
        prot = 4'b0000;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule